// File: doc/BRIEF.md
# DRAM Refresh Postponement Scheduler

This block tells a DRAM controller when to issue REFRESH commands. A free-running interval timer counts the average refresh interval, which is set at run time in clock cycles. Each time the interval expires, one refresh becomes owed. The command scheduler may let this debt grow while traffic is heavy, up to eight postponed refreshes. It then pays the debt back with one or more refreshes in a row, either when the scheduler reports a quiet moment or when the debt is full and the refresh is forced.

A REFRESH may only be issued with every bank precharged. The block therefore keeps an open flag and an open-time counter for each bank. These are driven by ACTIVATE, explicit PRECHARGE and auto-precharge events. The refresh request is withheld while any row is open. When the debt is full, the block asks for a precharge-all. Once the debt has reached its cap, a row that stays open longer than nine average intervals would push the next REFRESH past its deadline, so the block flags any row held open that long.

Top module: `refresh_postpone_sched`

## Requirements
- R1: With an interval setting of N cycles (N at least 2), one refresh becomes owed every N clock cycles. The first is owed at the Nth rising edge after reset is released.
- R2: The owed count never exceeds 8. If an interval expires while 8 refreshes are owed and no acknowledge is taken, the count stays at 8 and `debt_ovf` goes high and stays high until reset.
- R3: `ref_req` is high exactly when at least one refresh is owed, either `idle_hint` or `ref_urgent` is high, and no bank is open.
- R4: `ref_urgent` is high exactly when 8 refreshes are owed.
- R5: `prea_req` is high exactly when `ref_urgent` is high and at least one bank is open. It falls once every bank is closed.
- R6: A `ref_done` pulse taken while at least one refresh is owed lowers the owed count by one. With nothing owed it has no effect. In the cycle where an interval expires and a valid acknowledge is taken, the count is unchanged. Acknowledges may come on consecutive cycles.
- R7: A bank opens on its `act_evt` bit. It closes on its `pre_evt` or `autopre_evt` bit. If open and close arrive for the same bank in the same cycle, the bank ends up open.
- R8: Each bank counts the rising edges since its last ACTIVATE while it stays open. `row_open_viol` is high while any open bank has counted at least 9 times the interval setting. Closing the bank drops its contribution.
- R9: While reset is held and directly after it is released, all outputs are low, no refresh is owed and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trefi_cycles | input | TREFI_W | Average refresh interval in clock cycles (at least 2) |
| act_evt | input | NUM_BANKS | ACTIVATE issued to bank b this cycle |
| pre_evt | input | NUM_BANKS | Explicit PRECHARGE issued to bank b this cycle |
| autopre_evt | input | NUM_BANKS | Read or write with auto-precharge closing bank b this cycle |
| idle_hint | input | 1 | Scheduler has no pending traffic; a refresh may be taken early |
| ref_done | input | 1 | One REFRESH command has been issued |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Owed count at its cap; the refresh must not be postponed further |
| prea_req | output | 1 | Precharge all banks so the forced refresh can go out |
| row_open_viol | output | 1 | A row has been open for at least nine intervals |
| debt_ovf | output | 1 | Sticky: an interval expired with the owed count already full |

## Verification
The bench aims at the edges of the owed count. It checks that the first expiry lands on the Nth edge, since a design off by one would request refresh a cycle early or late. It checks that an expiry at the cap leaves the count at 8 and sets the sticky error; a design that wrapped would drop the urgent flag. It checks that a stray acknowledge at zero is ignored, since a design that honoured it would underflow and lose or invent refreshes. It also checks that an expiry and an acknowledge in the same cycle cancel out. On the bank side it checks ACTIVATE and PRECHARGE in the same cycle, where the wrong winner would let a refresh out with a row open. It checks the exact edge on which the open-time violation rises, and that the precharge-all request falls as soon as the last bank closes.

// File: rtl/refpost_pkg.sv
package refpost_pkg;

  // Next owed-refresh count given an interval expiry and an acknowledge.
  function automatic int unsigned debt_next(input int unsigned cur, input logic tick,
                                            input logic ack, input int unsigned cap);
    logic pay;
    pay = ack && (cur != 0);
    if (tick && !pay) return (cur >= cap) ? cap : cur + 1;
    if (pay && !tick) return cur - 1;
    return cur;
  endfunction

  // True when an expiry finds the count already full and nothing is paid.
  function automatic logic debt_overflows(input int unsigned cur, input logic tick,
                                          input logic ack, input int unsigned cap);
    return tick && !(ack && (cur != 0)) && (cur >= cap);
  endfunction

  // Longest gap between refreshes, and so the longest a row may stay open.
  function automatic int unsigned deadline_cycles(input int unsigned trefi,
                                                  input int unsigned mult);
    return trefi * mult;
  endfunction

endpackage

// File: rtl/refpost_interval_timer.sv
module refpost_interval_timer #(
  parameter int TREFI_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TREFI_W-1:0] trefi_cycles,
  output logic               tick_o
);
  localparam logic [TREFI_W-1:0] ONE = TREFI_W'(1);

  logic [TREFI_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= (trefi_cycles - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + ONE;
  end

  // R1: two expiries never come back to back for a legal interval
  assert_tick_spacing_R1: assert property (@(posedge clk)
    disable iff (!rst_n || trefi_cycles < TREFI_W'(2))
    tick_o |=> !tick_o);

endmodule

// File: rtl/refpost_debt_ctrl.sv
module refpost_debt_ctrl #(
  parameter int DEBT_MAX = 8,
  parameter int DEBT_W   = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ack_i,
  output logic [DEBT_W-1:0] debt_o,
  output logic              owed_o,
  output logic              full_o,
  output logic              ovf_o
);
  import refpost_pkg::*;

  localparam logic [DEBT_W-1:0] CAP = DEBT_W'(DEBT_MAX);

  logic [DEBT_W-1:0] debt_q;
  logic              ovf_q;
  logic              ovf_evt;

  assign ovf_evt = debt_overflows(32'(debt_q), tick_i, ack_i, DEBT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      debt_q <= DEBT_W'(debt_next(32'(debt_q), tick_i, ack_i, DEBT_MAX));
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  assign debt_o = debt_q;
  assign owed_o = (debt_q != '0);
  assign full_o = (debt_q == CAP);
  assign ovf_o  = ovf_q;

  // R2: the owed count stays within its cap
  assert_debt_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= CAP);

  // R2: an expiry at the cap without payment raises the sticky error
  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ack_i && full_o) |=> (ovf_q && full_o));

  // R6: the count moves by at most one per cycle
  assert_debt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (debt_q == $past(debt_q)) || (debt_q == $past(debt_q) + 1'b1) ||
    (debt_q + 1'b1 == $past(debt_q)));

  // R6: an acknowledge with nothing owed and no expiry changes nothing
  assert_stray_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !owed_o && !tick_i) |=> !owed_o);

endmodule

// File: rtl/refpost_bank_tracker.sv
module refpost_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] act_i,
  input  logic [NUM_BANKS-1:0] close_i,
  input  logic [ROW_W-1:0]     limit_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [NUM_BANKS-1:0] viol_o
);
  localparam logic [ROW_W-1:0] CNT_TOP = '1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        age_q  <= '0;
      end else if (act_i[b]) begin
        open_q <= 1'b1;
        age_q  <= '0;
      end else if (close_i[b]) begin
        open_q <= 1'b0;
      end else if (open_q && age_q != CNT_TOP) begin
        age_q <= age_q + 1'b1;
      end
    end

    assign open_o[b] = open_q;
    assign viol_o[b] = open_q && (age_q >= limit_i);

    // R7: activate wins; the bank is open with a fresh count afterwards
    assert_act_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      act_i[b] |=> (open_q && age_q == '0));

    // R7: a close without activate leaves the bank closed
    assert_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (close_i[b] && !act_i[b]) |=> !open_q);
  end

endmodule

// File: rtl/refresh_postpone_sched.sv
module refresh_postpone_sched #(
  parameter int NUM_BANKS = 4,
  parameter int TREFI_W   = 16,
  parameter int DEBT_MAX  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TREFI_W-1:0]   trefi_cycles,
  input  logic [NUM_BANKS-1:0] act_evt,
  input  logic [NUM_BANKS-1:0] pre_evt,
  input  logic [NUM_BANKS-1:0] autopre_evt,
  input  logic                 idle_hint,
  input  logic                 ref_done,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 prea_req,
  output logic                 row_open_viol,
  output logic                 debt_ovf
);
  import refpost_pkg::*;

  localparam int DEADLINE_MULT = DEBT_MAX + 1;
  localparam int MULT_W        = $clog2(DEADLINE_MULT + 1);
  localparam int ROW_W         = TREFI_W + MULT_W;
  localparam int DEBT_W        = $clog2(DEBT_MAX + 1);

  logic                 interval_tick;
  logic [DEBT_W-1:0]    debt;
  logic                 debt_owed;
  logic                 debt_full;
  logic [NUM_BANKS-1:0] bank_open;
  logic [NUM_BANKS-1:0] bank_viol;
  logic [NUM_BANKS-1:0] bank_close;
  logic [ROW_W-1:0]     row_limit;
  logic                 any_open;

  assign bank_close = pre_evt | autopre_evt;
  assign row_limit  = ROW_W'(deadline_cycles(32'(trefi_cycles), DEADLINE_MULT));

  refpost_interval_timer #(.TREFI_W(TREFI_W)) timer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trefi_cycles (trefi_cycles),
    .tick_o       (interval_tick)
  );

  refpost_debt_ctrl #(.DEBT_MAX(DEBT_MAX), .DEBT_W(DEBT_W)) debt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (interval_tick),
    .ack_i  (ref_done),
    .debt_o (debt),
    .owed_o (debt_owed),
    .full_o (debt_full),
    .ovf_o  (debt_ovf)
  );

  refpost_bank_tracker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) banks_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act_evt),
    .close_i (bank_close),
    .limit_i (row_limit),
    .open_o  (bank_open),
    .viol_o  (bank_viol)
  );

  assign any_open      = |bank_open;
  assign ref_urgent    = debt_full;
  assign ref_req       = debt_owed && (idle_hint || debt_full) && !any_open;
  assign prea_req      = debt_full && any_open;
  assign row_open_viol = |bank_viol;

  // R3: a refresh is never offered while a row is open
  assert_req_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (bank_open == '0));

  // R5: precharge-all only while the refresh is forced
  assert_prea_urgent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prea_req |-> (ref_urgent && debt != '0));

  // R8: a violation needs an open row
  assert_viol_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_open_viol |-> any_open);

  // R4: urgency implies something is owed
  assert_urgent_owed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> debt_owed);

endmodule

// File: tb/refresh_postpone_sched_tb_top.sv
module refresh_postpone_sched_tb_top;
  localparam int NB    = 4;
  localparam int TW    = 16;
  localparam int TREFI = 4;
  localparam int CAP   = 8;
  localparam int LIMIT = 9 * TREFI;

  // vector: idle, ack, act[4], pre[4], apre[4], repeat count[8]
  localparam int NVEC = 14;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000, 8'd1},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 8'd20},
    {1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0001, 8'd1},
    {1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000, 8'd3},
    {1'b0, 1'b0, 4'b0110, 4'b0000, 4'b0000, 8'd1},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 8'd40},
    {1'b0, 1'b0, 4'b0000, 4'b0010, 4'b0000, 8'd1},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 8'd2},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0100, 8'd1},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0000, 8'd12},
    {1'b1, 1'b0, 4'b1000, 4'b1000, 4'b0000, 8'd6},
    {1'b1, 1'b0, 4'b0000, 4'b0000, 4'b1000, 8'd1},
    {1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000, 8'd5},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0000, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] trefi_cycles = TW'(TREFI);
  logic [NB-1:0] act_evt = '0, pre_evt = '0, autopre_evt = '0;
  logic          idle_hint = 1'b0, ref_done = 1'b0;
  logic          ref_req, ref_urgent, prea_req, row_open_viol, debt_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, kept from the requirements
  int m_cnt, m_debt;
  bit m_ovf;
  bit m_open [NB];
  int m_age  [NB];

  always #5 clk = ~clk;

  refresh_postpone_sched #(.NUM_BANKS(NB), .TREFI_W(TW), .DEBT_MAX(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .trefi_cycles(trefi_cycles),
    .act_evt(act_evt), .pre_evt(pre_evt), .autopre_evt(autopre_evt),
    .idle_hint(idle_hint), .ref_done(ref_done),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .prea_req(prea_req),
    .row_open_viol(row_open_viol), .debt_ovf(debt_ovf)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_debt = 0; m_ovf = 0;
      for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_age[b] = 0; end
    end else begin
      bit tick, pay;
      tick = (m_cnt >= TREFI - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      pay = ref_done && (m_debt > 0);
      if (tick && !pay) begin
        if (m_debt == CAP) m_ovf = 1; else m_debt++;
      end else if (pay && !tick) m_debt--;
      for (int b = 0; b < NB; b++) begin
        if (act_evt[b]) begin m_open[b] = 1; m_age[b] = 0; end
        else if (pre_evt[b] || autopre_evt[b]) m_open[b] = 0;
        else if (m_open[b]) m_age[b]++;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    bit any_open, viol, urg;
    any_open = 0; viol = 0;
    for (int b = 0; b < NB; b++) begin
      if (m_open[b]) any_open = 1;
      if (m_open[b] && m_age[b] >= LIMIT) viol = 1;
    end
    urg = (m_debt == CAP);
    chk(ref_urgent, urg, "R4 urgent");
    chk(ref_req, (m_debt != 0) && (idle_hint || urg) && !any_open, "R3 ref_req");
    chk(prea_req, urg && any_open, "R5 prea_req");
    chk(row_open_viol, viol, "R8 row_open_viol");
    chk(debt_ovf, m_ovf, "R2 debt_ovf");
  endtask

  task automatic step(input logic i, input logic a, input logic [NB-1:0] ac,
                      input logic [NB-1:0] pr, input logic [NB-1:0] ap);
    @(negedge clk);
    idle_hint = i; ref_done = a; act_evt = ac; pre_evt = pr; autopre_evt = ap;
    #1;
    cmp_model();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_hint = 0; ref_done = 0; act_evt = '0; pre_evt = '0; autopre_evt = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-timeout: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #1;
    chk(ref_req, 1'b0, "R9 ref_req in reset");
    chk(prea_req, 1'b0, "R9 prea_req in reset");
    do_reset();
    chk(ref_req, 1'b0, "R9 ref_req after reset");
    chk(ref_urgent, 1'b0, "R9 urgent after reset");
    chk(prea_req, 1'b0, "R9 prea_req after reset");
    chk(row_open_viol, 1'b0, "R9 viol after reset");
    chk(debt_ovf, 1'b0, "R9 ovf after reset");

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int r = 0; r < int'(VEC[v][7:0]); r++)
        step(VEC[v][21], VEC[v][20], VEC[v][19:16], VEC[v][15:12], VEC[v][11:8]);
    end

    // R1 and R6: first expiry on edge 4; stray acknowledges ignored
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      step(1'b1, (k <= 3 || k == 5), (k == 7) ? 4'b1000 : 4'b0000,
           (k == 7) ? 4'b1000 : 4'b0000, (k == 8) ? 4'b1000 : 4'b0000);
      if (k <= 3) chk(ref_req, 1'b0, "R1 no refresh owed before edge 4");
      if (k == 4) chk(ref_req, 1'b1, "R1/R6 refresh owed at edge 4, stray ack ignored");
      if (k == 6) chk(ref_req, 1'b0, "R6 acknowledge paid the debt");
      if (k == 8) chk(ref_req, 1'b0, "R7 activate wins over same-cycle precharge");
      if (k == 9) chk(ref_req, 1'b1, "R7 auto-precharge closes the bank");
    end

    // R2, R4, R5, R8: hold a row open through the deadline
    do_reset();
    for (int k = 1; k <= 41; k++) begin
      step(1'b0, (k == 39), (k == 1) ? 4'b0001 : 4'b0000,
           (k == 38) ? 4'b0001 : 4'b0000, 4'b0000);
      if (k == 31) chk(ref_urgent, 1'b0, "R4 not urgent at 7 owed");
      if (k == 32) chk(ref_urgent, 1'b1, "R4 urgent at 8 owed");
      if (k == 32) chk(prea_req, 1'b1, "R5 precharge-all with a bank open");
      if (k == 35) chk(debt_ovf, 1'b0, "R2 no overflow yet");
      if (k == 36) chk(debt_ovf, 1'b1, "R2 overflow on expiry at cap");
      if (k == 36) chk(ref_urgent, 1'b1, "R2 count held at cap");
      if (k == 37) chk(row_open_viol, 1'b0, "R8 no violation one edge early");
      if (k == 38) chk(row_open_viol, 1'b1, "R8 violation at nine intervals");
      if (k == 39) chk(row_open_viol, 1'b0, "R8 violation drops on close");
      if (k == 39) chk(prea_req, 1'b0, "R5 precharge-all drops when all closed");
      if (k == 39) chk(ref_req, 1'b1, "R3 forced refresh offered without idle");
      if (k == 40) chk(ref_urgent, 1'b1, "R6 expiry and acknowledge cancel");
      if (k == 41) chk(debt_ovf, 1'b1, "R2 overflow flag sticky");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule